// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Controller

This block lets up to four processor cores ring one another. Every ordered pair of cores (sender, receiver) owns a small set of registers. The sender loads an optional 30-bit scratch word and then writes a message word. A message write with bit 31 set latches a pending flag for that pair, and the receiver's interrupt line rises. The receiver reads the payload and releases the flag by writing a one to bit 31 of the pair's completion register. A per-receiver busy enable mask chooses which senders may interrupt it. A per-sender done enable mask can record a done event, and so interrupt the sender, at the moment a receiver releases the flag.

All cores share one register port. Each access carries the index of the core that issues it. A core can only reach its own bank and its own mask registers. The interrupt outputs are levels formed from registered state, so they change on the clock edge that follows the write that causes the change.

Top module: `idc_doorbell`

## Requirements
- R1: After reset, every pending flag, done-pending bit, mask and payload is zero, every interrupt output is low, and every readable register returns zero.
- R2: A message write with bit 31 set, at bank b offset 16*j, latches the flag of pair (sender b, receiver j). A read of that register returns the flag in bit 31 and the stored bits 30:0.
- R3: A message write with bit 31 clear stores bits 30:0 and leaves the pair's flag and every interrupt output unchanged.
- R4: A completion write at bank b offset 16*j+8 acts on pair (sender j, receiver b). If bit 31 is one, it clears the flag. If bit 31 is zero, the flag stays set. In both cases bits 30:0 are stored and read back under the current flag in bit 31.
- R5: Interrupt output of core t is the OR, over every sender s including t itself, of flag(s,t) AND busy enable bit s of core t, ORed with core t's done-pending bits. The output changes in the cycle after the causing write.
- R6: A pending flag whose sender bit is clear in the receiver's busy enable mask does not raise the receiver's interrupt. Setting that bit later raises it.
- R7: The extension register (offset +4) and the completion-extension register (offset +C) each hold 30 bits. They read back with bits 31:30 equal to zero and have no effect on any interrupt.
- R8: When a completion write clears flag(s,t) while bit t of core s's done enable mask is set, done-pending bit t of core s is set and core s's interrupt rises. A write of one to that bit in core s's done-pending register clears it. With the enable bit clear, nothing is recorded.
- R9: Address map, with N cores: bank b spans 16*N bytes starting at 16*N*b. Core c's mask registers start at 16*N*N + 16*c, with busy enable at +0 (bit per sender), done enable at +4 (bit per receiver) and done pending at +8 (bit per receiver). An access whose bank or mask block does not match the issuing core index is ignored: a write changes nothing and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busCore | input | 2 | Index of the core issuing the access |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| irq | output | NUM_CORES | Level interrupt, one per core |

## Verification
The table rings doorbells between neighbouring cores, from a core to itself, and toward a core whose busy mask is still closed. These cases separate the raw flag from the masked interrupt level and show that the self pair counts. Completion writes are issued with bit 31 clear and set, and with the done enable open and closed, so that a release, a no-op and a done event each leave a different pattern on the interrupt lines. Accesses from a core into another core's bank or mask block, together with message writes that leave bit 31 clear, show that the ignore rule and the trigger rule leave state untouched. A reset in mid-run with a flag pending checks that all state returns to zero.

// File: rtl/idc_pkg.sv
package idc_pkg;
  localparam int IDX_W = 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_MSG, RD_EXT, RD_COMP, RD_CEXT, RD_BEN, RD_DEN, RD_DPEND
  } rdSel_e;

  typedef struct packed {
    logic             wrMsg;
    logic             wrExt;
    logic             wrComp;
    logic             wrCompExt;
    logic             wrBusyEn;
    logic             wrDoneEn;
    logic             wrDonePend;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] srcIdx;
    logic [IDX_W-1:0] tgtIdx;
    logic [IDX_W-1:0] ownIdx;
  } strobe_t;
endpackage

// File: rtl/idc_ctrl.sv
module idc_ctrl
  import idc_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 9
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [IDX_W-1:0]  busCore,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes
);
  localparam logic [31:0] BANK_BYTES = 32'(16 * NUM_CORES);
  localparam logic [31:0] PAIR_BYTES = 32'(16 * NUM_CORES * NUM_CORES);
  localparam logic [31:0] MASK_BYTES = 32'(16 * NUM_CORES);

  logic [31:0] addrU;
  logic [31:0] bankNum;
  logic [31:0] entryNum;
  logic [31:0] regNum;
  logic [31:0] maskOff;
  rdSel_e      sel;
  logic        hit;

  always_comb begin
    strobes  = '0;
    sel      = RD_NONE;
    hit      = 1'b0;
    addrU    = 32'(busAddr);
    bankNum  = '0;
    entryNum = '0;
    regNum   = '0;
    maskOff  = '0;
    if (addrU < PAIR_BYTES) begin
      bankNum  = addrU / BANK_BYTES;
      entryNum = (addrU % BANK_BYTES) / 32'd16;
      regNum   = (addrU % 32'd16) / 32'd4;
      hit      = busValid && (bankNum == 32'(busCore));
      strobes.ownIdx = bankNum[IDX_W-1:0];
      case (regNum[1:0])
        2'd0: sel = RD_MSG;
        2'd1: sel = RD_EXT;
        2'd2: sel = RD_COMP;
        default: sel = RD_CEXT;
      endcase
      if (regNum[1]) begin
        strobes.srcIdx = entryNum[IDX_W-1:0];
        strobes.tgtIdx = bankNum[IDX_W-1:0];
      end else begin
        strobes.srcIdx = bankNum[IDX_W-1:0];
        strobes.tgtIdx = entryNum[IDX_W-1:0];
      end
    end else if (addrU < PAIR_BYTES + MASK_BYTES) begin
      maskOff = addrU - PAIR_BYTES;
      bankNum = maskOff / 32'd16;
      regNum  = (maskOff % 32'd16) / 32'd4;
      hit     = busValid && (bankNum == 32'(busCore)) && (regNum != 32'd3);
      strobes.ownIdx = bankNum[IDX_W-1:0];
      case (regNum[1:0])
        2'd0: sel = RD_BEN;
        2'd1: sel = RD_DEN;
        default: sel = RD_DPEND;
      endcase
    end

    if (hit) begin
      if (busWrite) begin
        strobes.wrMsg      = (sel == RD_MSG);
        strobes.wrExt      = (sel == RD_EXT);
        strobes.wrComp     = (sel == RD_COMP);
        strobes.wrCompExt  = (sel == RD_CEXT);
        strobes.wrBusyEn   = (sel == RD_BEN);
        strobes.wrDoneEn   = (sel == RD_DEN);
        strobes.wrDonePend = (sel == RD_DPEND);
      end else begin
        strobes.rdSel = sel;
      end
    end
  end
endmodule

// File: rtl/idc_datapath.sv
module idc_datapath
  import idc_pkg::*;
#(
  parameter int NUM_CORES = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_CORES-1:0] irq
);
  localparam int PAIRS = NUM_CORES * NUM_CORES;

  logic [PAIRS-1:0] flagVec;   // index src*N+tgt
  logic [PAIRS-1:0] doneVec;   // index src*N+tgt
  logic [30:0]      msgArr  [PAIRS];
  logic [30:0]      compArr [PAIRS];
  logic [29:0]      extArr  [PAIRS];
  logic [29:0]      cextArr [PAIRS];
  logic [NUM_CORES-1:0] busyArr [NUM_CORES];
  logic [NUM_CORES-1:0] doneEnArr [NUM_CORES];

  for (genvar s = 0; s < NUM_CORES; s++) begin : gSrc
    for (genvar t = 0; t < NUM_CORES; t++) begin : gTgt
      logic        flagQ, doneQ, pairSel, setHit, clrHit, doneSet, doneClr;
      logic [30:0] msgQ, compQ;
      logic [29:0] extQ, cextQ;

      assign pairSel = (strobes.srcIdx == IDX_W'(s)) && (strobes.tgtIdx == IDX_W'(t));
      assign setHit  = pairSel && strobes.wrMsg && wdata[31];
      assign clrHit  = pairSel && strobes.wrComp && wdata[31];
      assign doneSet = clrHit && flagQ && doneEnArr[s][t];
      assign doneClr = strobes.wrDonePend && (strobes.ownIdx == IDX_W'(s)) && wdata[t];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          flagQ <= 1'b0;
          doneQ <= 1'b0;
          msgQ  <= '0;
          compQ <= '0;
          extQ  <= '0;
          cextQ <= '0;
        end else begin
          if (setHit)      flagQ <= 1'b1;
          else if (clrHit) flagQ <= 1'b0;
          if (doneSet)      doneQ <= 1'b1;
          else if (doneClr) doneQ <= 1'b0;
          if (pairSel && strobes.wrMsg)     msgQ  <= wdata[30:0];
          if (pairSel && strobes.wrComp)    compQ <= wdata[30:0];
          if (pairSel && strobes.wrExt)     extQ  <= wdata[29:0];
          if (pairSel && strobes.wrCompExt) cextQ <= wdata[29:0];
        end
      end

      assign flagVec[s*NUM_CORES+t] = flagQ;
      assign doneVec[s*NUM_CORES+t] = doneQ;
      assign msgArr[s*NUM_CORES+t]  = msgQ;
      assign compArr[s*NUM_CORES+t] = compQ;
      assign extArr[s*NUM_CORES+t]  = extQ;
      assign cextArr[s*NUM_CORES+t] = cextQ;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    logic [NUM_CORES-1:0] busyQ, doneEnQ;
    logic                 lineHit;
    logic                 ownSel;

    assign ownSel = (strobes.ownIdx == IDX_W'(c));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyQ   <= '0;
        doneEnQ <= '0;
      end else begin
        if (ownSel && strobes.wrBusyEn) busyQ   <= wdata[NUM_CORES-1:0];
        if (ownSel && strobes.wrDoneEn) doneEnQ <= wdata[NUM_CORES-1:0];
      end
    end

    assign busyArr[c]   = busyQ;
    assign doneEnArr[c] = doneEnQ;

    always_comb begin
      lineHit = 1'b0;
      for (int s = 0; s < NUM_CORES; s++) begin
        lineHit = lineHit | (flagVec[s*NUM_CORES+c] & busyQ[s]) | doneVec[c*NUM_CORES+s];
      end
    end
    assign irq[c] = lineHit;
  end

  logic [31:0] pairIdx;
  logic [31:0] ownNum;

  always_comb begin
    pairIdx = 32'(strobes.srcIdx) * 32'(NUM_CORES) + 32'(strobes.tgtIdx);
    ownNum  = 32'(strobes.ownIdx);
    rdata   = '0;
    if (pairIdx < 32'(PAIRS) && ownNum < 32'(NUM_CORES)) begin
      case (strobes.rdSel)
        RD_MSG:  rdata = {flagVec[pairIdx], msgArr[pairIdx]};
        RD_EXT:  rdata = {2'b00, extArr[pairIdx]};
        RD_COMP: rdata = {flagVec[pairIdx], compArr[pairIdx]};
        RD_CEXT: rdata = {2'b00, cextArr[pairIdx]};
        RD_BEN:  rdata = 32'(busyArr[ownNum]);
        RD_DEN:  rdata = 32'(doneEnArr[ownNum]);
        RD_DPEND: begin
          for (int t = 0; t < NUM_CORES; t++) rdata[t] = doneVec[ownNum*NUM_CORES+t];
        end
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/idc_doorbell.sv
module idc_doorbell
  import idc_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [IDX_W-1:0]     busCore,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_CORES-1:0] irq
);
  strobe_t strobes;

  idc_ctrl #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) uCtrl (
    .busValid(busValid),
    .busWrite(busWrite),
    .busCore (busCore),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  idc_datapath #(.NUM_CORES(NUM_CORES)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .irq    (irq)
  );
endmodule

// File: rtl/idc_doorbell_chk.sv
module idc_doorbell_chk #(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [1:0]           busCore,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [31:0]          busWdata,
  input logic [31:0]          busRdata,
  input logic [NUM_CORES-1:0] irq
);
  localparam logic [31:0] BANK = 32'(16 * NUM_CORES);
  localparam logic [31:0] PAIR = 32'(16 * NUM_CORES * NUM_CORES);

  logic [31:0] a;
  logic        inPair, inMask, foreign;
  logic [1:0]  kind;

  always_comb begin
    a       = 32'(busAddr);
    inPair  = a < PAIR;
    inMask  = !inPair && (a < PAIR + BANK);
    kind    = busAddr[3:2];
    foreign = 1'b0;
    if (inPair)      foreign = (a / BANK) != 32'(busCore);
    else if (inMask) foreign = ((a - PAIR) / 32'd16) != 32'(busCore);
  end

  // R9
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && foreign |=> $stable(irq));

  // R9
  foreign_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite && foreign |-> busRdata == 32'd0);

  // R3
  quiet_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && inPair && kind == 2'd0 && !busWdata[31] |=> $stable(irq));

  // R4
  quiet_comp_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && inPair && kind == 2'd2 && !busWdata[31] |=> $stable(irq));

  // R7
  ext_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && inPair && kind[0] |=> $stable(irq));

  // R7
  ext_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite && inPair && kind[0] |-> busRdata[31:30] == 2'b00);

  // R5
  read_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite |=> $stable(irq));
endmodule

bind idc_doorbell idc_doorbell_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) chk (.*);

// File: tb/idc_doorbell_test.sv
module idc_doorbell_test;
  localparam int N = 3;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [1:0]    busCore = '0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [N-1:0]  irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  idc_doorbell #(.NUM_CORES(N), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busCore(busCore), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]    core;
    logic          wr;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [31:0]   expRd;
    logic [N-1:0]  expIrq;
  } vec_t;

  // Map for N=3: bank b at 0x30*b, entry j at +0x10*j; masks of core c at 0x90+0x10*c
  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 9'h0A0, 32'h7,        32'h0,        3'b000}, // R6 core1 busy mask open
    '{2'd0, 1'b1, 9'h014, 32'hFFFFFFFF, 32'h0,        3'b000}, // R7 ext write
    '{2'd0, 1'b0, 9'h014, 32'h0,        32'h3FFFFFFF, 3'b000}, // R7 ext read 30 bits
    '{2'd0, 1'b1, 9'h010, 32'h81000002, 32'h0,        3'b010}, // R2 R5 ring 0->1
    '{2'd1, 1'b0, 9'h038, 32'h0,        32'h80000000, 3'b010}, // R4 flag seen at completion
    '{2'd0, 1'b0, 9'h010, 32'h0,        32'h81000002, 3'b010}, // R2 payload readback
    '{2'd1, 1'b1, 9'h038, 32'h00000005, 32'h0,        3'b010}, // R4 zero bit31 keeps flag
    '{2'd1, 1'b0, 9'h038, 32'h0,        32'h80000005, 3'b010}, // R4 payload stored
    '{2'd1, 1'b1, 9'h038, 32'h80000000, 32'h0,        3'b000}, // R4 release
    '{2'd0, 1'b0, 9'h098, 32'h0,        32'h0,        3'b000}, // R8 no done without enable
    '{2'd0, 1'b1, 9'h094, 32'h2,        32'h0,        3'b000}, // R8 done enable target1
    '{2'd0, 1'b1, 9'h010, 32'h80000000, 32'h0,        3'b010}, // R2 ring again
    '{2'd1, 1'b1, 9'h038, 32'h80000000, 32'h0,        3'b001}, // R8 done interrupts sender
    '{2'd0, 1'b0, 9'h098, 32'h0,        32'h2,        3'b001}, // R8 done pending readback
    '{2'd0, 1'b1, 9'h098, 32'h2,        32'h0,        3'b000}, // R8 w1c done
    '{2'd0, 1'b1, 9'h000, 32'h80000000, 32'h0,        3'b000}, // R6 self ring masked
    '{2'd0, 1'b1, 9'h090, 32'h1,        32'h0,        3'b001}, // R5 R6 self pair counts
    '{2'd0, 1'b1, 9'h008, 32'h80000000, 32'h0,        3'b000}, // R4 self release, no done
    '{2'd2, 1'b1, 9'h010, 32'h80001234, 32'h0,        3'b000}, // R9 foreign write
    '{2'd0, 1'b0, 9'h010, 32'h0,        32'h0,        3'b000}, // R9 state untouched
    '{2'd2, 1'b0, 9'h090, 32'h0,        32'h0,        3'b000}, // R9 foreign read zero
    '{2'd2, 1'b1, 9'h06C, 32'hFFFFFFFF, 32'h0,        3'b000}, // R7 completion ext write
    '{2'd2, 1'b0, 9'h06C, 32'h0,        32'h3FFFFFFF, 3'b000}, // R7 completion ext read
    '{2'd0, 1'b1, 9'h020, 32'h80000000, 32'h0,        3'b000}, // R6 ring 0->2 masked
    '{2'd2, 1'b1, 9'h0B0, 32'h1,        32'h0,        3'b100}, // R6 open mask raises
    '{2'd2, 1'b1, 9'h068, 32'h80000000, 32'h0,        3'b000}, // R4 release 0->2
    '{2'd1, 1'b1, 9'h030, 32'h80000000, 32'h0,        3'b000}, // R6 ring 1->0, sender1 masked
    '{2'd0, 1'b1, 9'h090, 32'h3,        32'h0,        3'b001}, // R5 sender1 enabled
    '{2'd0, 1'b1, 9'h010, 32'h00000055, 32'h0,        3'b001}, // R3 no trigger
    '{2'd0, 1'b0, 9'h010, 32'h0,        32'h00000055, 3'b001}, // R3 payload without flag
    '{2'd1, 1'b0, 9'h030, 32'h0,        32'h80000000, 3'b001}  // R2 flag of pair 1->0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive after a falling edge, sample read data mid-phase, sample irq after the next falling edge
  task automatic access(input logic [1:0] core, input logic wr, input logic [AW-1:0] addr,
                        input logic [31:0] data, input bit chkRd, input logic [31:0] expRd,
                        input string req);
    busValid = 1'b1; busWrite = wr; busCore = core; busAddr = addr; busWdata = data;
    #5;
    if (chkRd) check(req, busRdata, expRd);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", 32'(irq), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", 32'(irq), 32'h0);
    access(2'd0, 1'b0, 9'h010, 32'h0, 1'b1, 32'h0, "R1 message reads zero");
    access(2'd1, 1'b0, 9'h0A0, 32'h0, 1'b1, 32'h0, "R1 mask reads zero");

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].core, VECS[i].wr, VECS[i].addr, VECS[i].data, !VECS[i].wr,
             VECS[i].expRd, $sformatf("table vector %0d read", i));
      check($sformatf("table vector %0d irq", i), 32'(irq), 32'(VECS[i].expIrq));
    end

    // R1 mid-run reset clears a pending ring and the masks
    access(2'd1, 1'b1, 9'h0A0, 32'h7, 1'b0, 32'h0, "R1");
    access(2'd0, 1'b1, 9'h010, 32'h80000000, 1'b0, 32'h0, "R1");
    check("R1 ring before reset", 32'(irq), 32'h3);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 irq after mid reset", 32'(irq), 32'h0);
    access(2'd1, 1'b0, 9'h038, 32'h0, 1'b1, 32'h0, "R1 flag cleared by reset");
    access(2'd1, 1'b0, 9'h0A0, 32'h0, 1'b1, 32'h0, "R1 mask cleared by reset");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule